// File: doc/BRIEF.md
# Packet capture record framer

This block turns each received Ethernet frame into a variable-length capture record. A record is a 16-byte header, then a zero offset byte and a zero pad byte, then the frame bytes. The two extra bytes place the layer-3 header of the frame on a 32-bit boundary within the record. Frames arrive one byte per beat with start and end markers. The frame's wire length and a 64-bit arrival timestamp are presented on the start beat. Records leave as a byte stream with their own start and end markers.

At the start beat of each frame the block works out how long the record will be. It compares that length with the free space reported by the downstream record buffer. When the space is short, the whole frame is discarded, and the only trace of it is a saturating loss count carried in the next record that is emitted. A snap mode truncates frames to a configured length and pads every record with zeros to a fixed size that is a multiple of 8 bytes.

The incoming stream is assumed to leave enough idle beats between frames for the 18 leading bytes of each record to drain. Ethernet's preamble and inter-frame gap provide this on a real link. A start beat is also refused, and counted as a loss, when the descriptor queue or the byte queue is full.

Top module: `cap_rec_framer`

## Requirements
- R1: Header byte order is: bytes 0-7 the timestamp, least significant byte first; byte 8 type; byte 9 flags; bytes 10-11 record length; bytes 12-13 loss count; bytes 14-15 wire length. Each 16-bit field is sent most significant byte first. The 18 leading bytes of a record go out on consecutive cycles.
- R2: The type byte is 2. Bytes 16 and 17 (offset and pad) are zero. The first frame byte is byte 18.
- R3: With snap mode off, the record length is wire length + 18, and all frame bytes are copied in arrival order.
- R4: With snap mode on, only the first snap_len bytes of a longer frame are copied. The wire length field still holds the original length. Flags bit 0 is 1 exactly when the frame was cut; the other flag bits are 0.
- R5: With snap mode on, every record is (snap_len + 18) rounded up to a multiple of 8 bytes long, with zero bytes after the frame data. A snap length of 44 gives 64-byte records.
- R6: At the start beat, a frame whose record length exceeds space_i is dropped whole: no byte of it is emitted. space_i equal to the record length is enough.
- R7: The loss count in a record equals the number of frames dropped since the previous emitted record. It restarts from zero after each emitted record.
- R8: The loss count saturates at 0xFFFF.
- R9: rec_sof_o marks the first byte and rec_eof_o the last byte of a record. The number of bytes between them, inclusive, equals the record length field.
- R10: During and just after reset no record byte is emitted, and the first record carries a loss count of 0.
- R11: The timestamp and wire length are sampled on the start beat. Later changes of in_ts_i have no effect on the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Frame byte valid |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame |
| in_data_i | input | 8 | Frame byte |
| in_wlen_i | input | 16 | Wire length of the frame, sampled on the start beat |
| in_ts_i | input | 64 | Arrival timestamp, sampled on the start beat |
| snap_en_i | input | 1 | Snap mode enable, sampled on the start beat |
| snap_len_i | input | 16 | Snap length in bytes, sampled on the start beat |
| space_i | input | 16 | Free bytes in the downstream record buffer |
| rec_valid_o | output | 1 | Record byte valid |
| rec_sof_o | output | 1 | First byte of a record |
| rec_eof_o | output | 1 | Last byte of a record |
| rec_data_o | output | 8 | Record byte |

## Verification
The bench targets the space comparison at its exact edge: 67 versus 68 free bytes for a 68-byte record. A design that compared with the wrong inequality would drop or emit one record too many. Runs of consecutive drops followed by an accepted frame check that the loss count covers every drop and then restarts. A design that cleared on drops or kept counting across records would carry a stale value. More than 65,535 back-to-back drops test saturation; a wrapping counter would report a small number. Snap-mode cases cover a frame longer than the snap length, a shorter one, and one exactly equal to it. A wrong truncation compare would set the flag or cut data in the equal case. Wrong rounding would give the 44-byte snap record a length other than 64. A single-byte frame checks the start beat that is also the last beat. A timestamp that changes after the start beat would show up in the header if it were sampled late.

// File: rtl/cap_rec_pkg.sv
package cap_rec_pkg;
  localparam int LEN_W       = 16;
  localparam int LOSS_W      = 16;
  localparam int TS_W        = 64;
  localparam int LEAD_BYTES  = 18;  // header plus offset/pad
  localparam int ALIGN_BYTES = 8;   // snap-mode record granule, power of two
  localparam logic [7:0] REC_TYPE_ETH = 8'd2;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [LEN_W-1:0]  rlen;
    logic [LEN_W-1:0]  wlen;
    logic [LEN_W-1:0]  cap;
    logic [LOSS_W-1:0] loss;
    logic              trunc;
  } rec_desc_t;
endpackage

// File: rtl/cap_rec_fifo.sv
module cap_rec_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cap_rec_admit.sv
module cap_rec_admit
  import cap_rec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic [7:0]        in_data_i,
  input  logic [LEN_W-1:0]  in_wlen_i,
  input  logic [TS_W-1:0]   in_ts_i,
  input  logic              snap_en_i,
  input  logic [LEN_W-1:0]  snap_len_i,
  input  logic [LEN_W-1:0]  space_i,
  input  logic              desc_full_i,
  input  logic              data_full_i,
  output logic              desc_push_o,
  output rec_desc_t         desc_o,
  output logic              data_push_o,
  output logic [7:0]        data_o
);
  localparam logic [LEN_W-1:0] LEAD     = LEN_W'(LEAD_BYTES);
  localparam logic [LEN_W-1:0] ROUND_UP = LEN_W'(LEAD_BYTES + ALIGN_BYTES - 1);
  localparam logic [LEN_W-1:0] GRAN_MSK = ~LEN_W'(ALIGN_BYTES - 1);

  logic              sof_w, trunc_w, ok_w, admit_w, drop_w, more_w;
  logic [LEN_W-1:0]  cap_w, rlen_w;
  logic              keep_q;
  logic [LEN_W-1:0]  cnt_q, cap_q;
  logic [LOSS_W-1:0] loss_q;

  always_comb begin
    sof_w   = in_valid_i && in_sof_i;
    trunc_w = snap_en_i && (in_wlen_i > snap_len_i);
    cap_w   = trunc_w ? snap_len_i : in_wlen_i;
    rlen_w  = snap_en_i ? ((snap_len_i + ROUND_UP) & GRAN_MSK) : (in_wlen_i + LEAD);
    // decided once per frame, so a record is emitted whole or not at all
    ok_w    = (space_i >= rlen_w) && !desc_full_i && !data_full_i;
    admit_w = sof_w && ok_w;
    drop_w  = sof_w && !ok_w;
    more_w  = in_valid_i && !in_sof_i && keep_q && (cnt_q < cap_q);

    data_push_o  = (admit_w && (cap_w != '0)) || more_w;
    data_o       = in_data_i;
    desc_push_o  = admit_w;
    desc_o.ts    = in_ts_i;
    desc_o.rlen  = rlen_w;
    desc_o.wlen  = in_wlen_i;
    desc_o.cap   = cap_w;
    desc_o.loss  = loss_q;
    desc_o.trunc = trunc_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= 1'b0;
      cnt_q  <= '0;
      cap_q  <= '0;
      loss_q <= '0;
    end else begin
      if (sof_w) begin
        keep_q <= admit_w && !in_eof_i;
        cnt_q  <= LEN_W'(1);
        cap_q  <= cap_w;
      end else if (in_valid_i) begin
        cnt_q <= cnt_q + LEN_W'(1);
        if (in_eof_i) keep_q <= 1'b0;
      end
      if (admit_w)                      loss_q <= '0;
      else if (drop_w && loss_q != '1)  loss_q <= loss_q + LOSS_W'(1);
    end
  end

  assert_lctr_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    admit_w |=> (loss_q == '0));
  assert_lctr_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_w && loss_q == '1) |=> (loss_q == '1));
  assert_drop_no_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_w |-> !data_push_o);
endmodule

// File: rtl/cap_rec_emit.sv
module cap_rec_emit
  import cap_rec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       desc_empty_i,
  input  rec_desc_t  desc_i,
  output logic       desc_pop_o,
  input  logic       data_empty_i,
  input  logic [7:0] data_i,
  output logic       data_pop_o,
  output logic       rec_valid_o,
  output logic       rec_sof_o,
  output logic       rec_eof_o,
  output logic [7:0] rec_data_o
);
  localparam logic [LEN_W-1:0] LEAD = LEN_W'(LEAD_BYTES);

  logic             busy_q;
  rec_desc_t        cur_q;
  logic [LEN_W-1:0] idx_q;
  logic             in_data_w, stall_w, fire_w, last_w;
  logic [7:0]       byte_w;

  always_comb begin
    in_data_w = (idx_q >= LEAD) && (idx_q < LEAD + cur_q.cap);
    stall_w   = in_data_w && data_empty_i;
    fire_w    = busy_q && !stall_w;
    last_w    = (idx_q == cur_q.rlen - LEN_W'(1));
    desc_pop_o = !busy_q && !desc_empty_i;
    data_pop_o = fire_w && in_data_w;

    byte_w = 8'h00;
    if (idx_q < LEAD) begin
      case (idx_q[4:0])
        5'd8:    byte_w = REC_TYPE_ETH;
        5'd9:    byte_w = {7'b0, cur_q.trunc};
        5'd10:   byte_w = cur_q.rlen[15:8];
        5'd11:   byte_w = cur_q.rlen[7:0];
        5'd12:   byte_w = cur_q.loss[15:8];
        5'd13:   byte_w = cur_q.loss[7:0];
        5'd14:   byte_w = cur_q.wlen[15:8];
        5'd15:   byte_w = cur_q.wlen[7:0];
        5'd16,
        5'd17:   byte_w = 8'h00;
        default: byte_w = cur_q.ts[{idx_q[2:0], 3'b000} +: 8];  // little-endian stamp
      endcase
    end else if (in_data_w) begin
      byte_w = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cur_q       <= '0;
      idx_q       <= '0;
      rec_valid_o <= 1'b0;
      rec_sof_o   <= 1'b0;
      rec_eof_o   <= 1'b0;
      rec_data_o  <= '0;
    end else begin
      rec_valid_o <= fire_w;
      rec_sof_o   <= fire_w && (idx_q == '0);
      rec_eof_o   <= fire_w && last_w;
      if (fire_w) rec_data_o <= byte_w;
      if (desc_pop_o) begin
        busy_q <= 1'b1;
        cur_q  <= desc_i;
        idx_q  <= '0;
      end else if (fire_w) begin
        idx_q <= idx_q + LEN_W'(1);
        if (last_w) busy_q <= 1'b0;
      end
    end
  end

  assert_sof_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_sof_o |-> rec_valid_o);
  assert_eof_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_eof_o) |=> !rec_valid_o);
  assert_hdr_burst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_sof_o |=> (rec_valid_o && !rec_sof_o));
endmodule

// File: rtl/cap_rec_framer.sv
module cap_rec_framer
  import cap_rec_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int DESC_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_sof_i,
  input  logic        in_eof_i,
  input  logic [7:0]  in_data_i,
  input  logic [15:0] in_wlen_i,
  input  logic [63:0] in_ts_i,
  input  logic        snap_en_i,
  input  logic [15:0] snap_len_i,
  input  logic [15:0] space_i,
  output logic        rec_valid_o,
  output logic        rec_sof_o,
  output logic        rec_eof_o,
  output logic [7:0]  rec_data_o
);
  localparam int DESC_W = $bits(rec_desc_t);

  rec_desc_t  push_desc, head_desc;
  logic       desc_push, desc_pop, desc_full, desc_empty;
  logic       data_push, data_pop, data_full, data_empty;
  logic [7:0] push_byte, head_byte;

  cap_rec_admit u_admit (
    .clk_i, .rst_ni, .in_valid_i, .in_sof_i, .in_eof_i, .in_data_i,
    .in_wlen_i, .in_ts_i, .snap_en_i, .snap_len_i, .space_i,
    .desc_full_i (desc_full),
    .data_full_i (data_full),
    .desc_push_o (desc_push),
    .desc_o      (push_desc),
    .data_push_o (data_push),
    .data_o      (push_byte)
  );

  cap_rec_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_desc_q (
    .clk_i, .rst_ni,
    .push_i (desc_push), .din_i (push_desc),
    .pop_i  (desc_pop),  .dout_o (head_desc),
    .full_o (desc_full), .empty_o (desc_empty)
  );

  cap_rec_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk_i, .rst_ni,
    .push_i (data_push), .din_i (push_byte),
    .pop_i  (data_pop),  .dout_o (head_byte),
    .full_o (data_full), .empty_o (data_empty)
  );

  cap_rec_emit u_emit (
    .clk_i, .rst_ni,
    .desc_empty_i (desc_empty),
    .desc_i       (head_desc),
    .desc_pop_o   (desc_pop),
    .data_empty_i (data_empty),
    .data_i       (head_byte),
    .data_pop_o   (data_pop),
    .rec_valid_o, .rec_sof_o, .rec_eof_o, .rec_data_o
  );
endmodule

// File: tb/cap_rec_framer_tb.sv
module cap_rec_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, snap_en;
  logic [7:0]  in_data;
  logic [15:0] in_wlen, snap_len, space;
  logic [63:0] in_ts;
  logic        rec_valid, rec_sof, rec_eof;
  logic [7:0]  rec_data;

  always #2.5 clk = ~clk;

  cap_rec_framer u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_sof_i (in_sof), .in_eof_i (in_eof),
    .in_data_i (in_data), .in_wlen_i (in_wlen), .in_ts_i (in_ts),
    .snap_en_i (snap_en), .snap_len_i (snap_len), .space_i (space),
    .rec_valid_o (rec_valid), .rec_sof_o (rec_sof), .rec_eof_o (rec_eof),
    .rec_data_o (rec_data)
  );

  typedef struct packed {
    logic [15:0] wlen;
    logic        snap;
    logic [15:0] slen;
    logic [15:0] space;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'd60,  1'b0, 16'd0,  16'd1000, 8'h10},  // plain
    '{16'd64,  1'b1, 16'd44, 16'd1000, 8'h21},  // cut to 44, 64-byte record
    '{16'd30,  1'b1, 16'd44, 16'd1000, 8'h32},  // short, zero padded
    '{16'd44,  1'b1, 16'd44, 16'd1000, 8'h43},  // equal to snap, no cut
    '{16'd50,  1'b0, 16'd0,  16'd67,   8'h54},  // one byte short: drop
    '{16'd50,  1'b0, 16'd0,  16'd68,   8'h65},  // exact fit
    '{16'd1,   1'b0, 16'd0,  16'd19,   8'h76},  // single-byte frame
    '{16'd100, 1'b1, 16'd45, 16'd1000, 8'h87},  // 63 rounds to 64
    '{16'd20,  1'b1, 16'd60, 16'd79,   8'h98},  // 80-byte record, drop
    '{16'd40,  1'b0, 16'd0,  16'd58,   8'ha9},
    '{16'd70,  1'b0, 16'd0,  16'd10,   8'hba},  // drop
    '{16'd70,  1'b0, 16'd0,  16'd87,   8'hcb},  // drop
    '{16'd70,  1'b0, 16'd0,  16'd88,   8'hdc}   // two losses reported
  };

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] cap_data [0:4095];
  bit         cap_sof  [0:4095];
  bit         cap_eof  [0:4095];
  int         cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && rec_valid && cap_n < 4096) begin
      cap_data[cap_n] = rec_data;
      cap_sof[cap_n]  = rec_sof;
      cap_eof[cap_n]  = rec_eof;
      cap_n++;
    end
  end

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rlen(input int wlen, input bit snap, input int slen);
    return snap ? ((slen + 18 + 7) / 8) * 8 : wlen + 18;
  endfunction

  function automatic logic [15:0] be16(input int p);
    return {cap_data[p], cap_data[p+1]};
  endfunction

  task automatic send_frame(input int wlen, input bit snap, input int slen,
                            input int spc, input logic [7:0] seed, input logic [63:0] ts);
    for (int j = 0; j < wlen; j++) begin
      in_valid = 1'b1;
      in_sof   = (j == 0);
      in_eof   = (j == wlen - 1);
      in_data  = 8'(int'(seed) + j * 3);
      in_wlen  = 16'(wlen);
      in_ts    = (j == 0) ? ts : ~ts;  // R11: later values must not leak in
      snap_en  = snap;
      snap_len = 16'(slen);
      space    = 16'(spc);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic check_rec(input int start, input int wlen, input bit snap, input int slen,
                           input logic [7:0] seed, input logic [63:0] ts, input int loss,
                           input string loss_req);
    bit          cut;
    int          ecap, erl, mism, pad_bad;
    logic [63:0] got_ts;
    cut  = snap && (wlen > slen);
    ecap = cut ? slen : wlen;
    erl  = exp_rlen(wlen, snap, slen);
    check_eq("R9", "record byte count", 64'(cap_n - start), 64'(erl));
    check_eq("R9", "sof on first byte", 64'(cap_sof[start]), 64'd1);
    check_eq("R9", "eof on last byte", 64'(cap_eof[start + erl - 1]), 64'd1);
    got_ts = '0;
    for (int k = 0; k < 8; k++) got_ts |= 64'(cap_data[start + k]) << (8 * k);
    check_eq("R1 R11", "timestamp", got_ts, ts);
    check_eq("R2", "type byte", 64'(cap_data[start + 8]), 64'd2);
    check_eq("R4", "flags", 64'(cap_data[start + 9]), 64'(cut));
    check_eq(snap ? "R5" : "R3", "rlen field", 64'(be16(start + 10)), 64'(erl));
    check_eq(loss_req, "loss field", 64'(be16(start + 12)), 64'(loss));
    check_eq("R4", "wlen field", 64'(be16(start + 14)), 64'(wlen));
    check_eq("R2", "offset/pad", 64'(be16(start + 16)), 64'd0);
    mism = 0;
    for (int j = 0; j < ecap; j++)
      if (cap_data[start + 18 + j] !== 8'(int'(seed) + j * 3)) mism++;
    check_eq(cut ? "R4" : "R3", "payload mismatches", 64'(mism), 64'd0);
    if (snap) begin
      pad_bad = 0;
      for (int j = 18 + ecap; j < erl; j++)
        if (cap_data[start + j] !== 8'h00) pad_bad++;
      check_eq("R5", "nonzero pad bytes", 64'(pad_bad), 64'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int loss_m, start;
    logic [63:0] ts;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    in_wlen = '0; in_ts = '0; snap_en = 1'b0; snap_len = '0; space = '0;
    repeat (4) @(negedge clk);
    check_eq("R10", "valid in reset", 64'(rec_valid), 64'd0);
    check_eq("R10", "sof/eof in reset", 64'({rec_sof, rec_eof}), 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R10", "bytes after reset", 64'(cap_n), 64'd0);

    loss_m = 0;
    for (int i = 0; i < NV; i++) begin
      int erl;
      start = cap_n;
      ts = {32'h5000_0000 + 32'(i), 32'ha5a5_0000 + 32'(i * 'h111)};
      send_frame(int'(VEC[i].wlen), VEC[i].snap, int'(VEC[i].slen), int'(VEC[i].space),
                 VEC[i].seed, ts);
      repeat (160) @(negedge clk);
      erl = exp_rlen(int'(VEC[i].wlen), VEC[i].snap, int'(VEC[i].slen));
      if (int'(VEC[i].space) < erl) begin
        check_eq("R6", "bytes of dropped frame", 64'(cap_n - start), 64'd0);
        if (loss_m < 65535) loss_m++;
      end else begin
        check_rec(start, int'(VEC[i].wlen), VEC[i].snap, int'(VEC[i].slen), VEC[i].seed,
                  ts, loss_m, (i == 0) ? "R10" : "R7");
        loss_m = 0;
      end
    end

    // R8: more drops than the counter can hold
    start = cap_n;
    for (int k = 0; k < 65540; k++) begin
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_wlen = 16'd1;
      snap_en = 1'b0; space = 16'd0; in_data = 8'(k);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (40) @(negedge clk);
    check_eq("R6", "bytes during drop burst", 64'(cap_n - start), 64'd0);

    start = cap_n;
    ts = 64'h0123_4567_89ab_cdef;
    send_frame(10, 1'b0, 0, 1000, 8'h3c, ts);
    repeat (120) @(negedge clk);
    check_rec(start, 10, 1'b0, 0, 8'h3c, ts, 65535, "R8");

    start = cap_n;
    ts = 64'hfedc_ba98_7654_3210;
    send_frame(12, 1'b0, 0, 1000, 8'h4d, ts);
    repeat (120) @(negedge clk);
    check_rec(start, 12, 1'b0, 0, 8'h4d, ts, 0, "R7");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule